// File: doc/BRIEF.md
# Bus Error Capture Unit

This block records the details of a failing bus transfer. An external detector raises a single-cycle error event with the transfer's address, data and attributes. The attributes are whether it was an instruction fetch or a data access, the privilege level, the access size, the direction and the number of the requesting master. The first such event is latched, and the unit then holds a pending capture. While a capture is pending, the level interrupt output stays high.

Any later event that arrives while the capture is pending leaves the stored record untouched. It only sets a sticky overrun flag. Software reads the record through a small 32-bit read port, with one word each for address, attributes and data. It then pulses a clear strobe to re-arm the unit. The block does not detect errors and takes no part in the bus protocol.

Top module: `buserr_capture`

## Requirements
- R1: After reset every readable word is zero and `irq` is low.
- R2: An error event accepted while no capture is pending stores `err_addr` and `err_data` in the cycle after the event.
- R3: The attribute word places the fetch/data flag (0 fetch, 1 data) in bit 0, privilege (0 user, 1 privileged) in bit 1, the size code in bits 5:4 stored as given (00 byte, 01 halfword, 10 word, 11 reserved), direction (0 read, 1 write) in bit 7 and the master number in bits 11:8.
- R4: Attribute bits 3:2, bit 6 and bits 30:12 always read as zero.
- R5: While a capture is pending, a new error event without a clear leaves the stored address, data and attribute bits 11:0 unchanged.
- R6: A new error event while a capture is pending sets attribute bit 31 (overrun). The bit stays set until a clear.
- R7: `irq` is high exactly while a capture is pending, from the cycle after the accepted event until the cycle after a clear.
- R8: A clear without an error event ends the pending state and resets overrun. The stored address, data and attribute bits 11:0 are retained.
- R9: An error event and a clear in the same cycle capture the new event as a fresh first error, with overrun zero and the capture pending.
- R10: `rd_data` is combinational from `rd_idx`: 0 selects the address, 1 the attributes, 2 the data, and 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Error event strobe |
| err_addr | input | ADDR_W | Address of the failing transfer |
| err_data | input | DATA_W | Data of the failing transfer |
| err_is_data | input | 1 | 1 for a data access, 0 for a fetch |
| err_priv | input | 1 | 1 for privileged, 0 for user |
| err_size | input | 2 | Access size code |
| err_write | input | 1 | 1 for a write, 0 for a read |
| err_master | input | MST_W | Requesting master number |
| clr | input | 1 | Clear strobe that re-arms the unit |
| rd_idx | input | 2 | Read word select |
| rd_data | output | 32 | Selected read word |
| irq | output | 1 | Level interrupt, high while a capture is pending |

## Verification
The bench builds the block with its default widths: 32-bit address and data and a 4-bit master number. With these widths the bench can drive all-ones and alternating patterns across every data bit, and can place master 15 against the top of the field next to the reserved bits. The size code 11 and every attribute flag are driven both set and clear. All four read words are swept after every clock. This catches a misplaced field, leakage into a reserved bit, and a corrupted frozen record during overrun. The simultaneous error-and-clear case is run both while the unit is pending and while it is idle.

// File: rtl/buserr_capture.sv
module buserr_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MST_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [DATA_W-1:0] err_data,
  input  logic              err_is_data,
  input  logic              err_priv,
  input  logic [1:0]        err_size,
  input  logic              err_write,
  input  logic [MST_W-1:0]  err_master,
  input  logic              clr,
  input  logic [1:0]        rd_idx,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam int REG_W = 32;

  logic              pend_q, ovr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              kind_q, priv_q, wr_q;
  logic [1:0]        size_q;
  logic [MST_W-1:0]  mst_q;
  logic              take;
  logic [3:0]        mst_ext;
  logic [REG_W-1:0]  attr_word;

  assign take = err_valid & (~pend_q | clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      kind_q <= 1'b0;
      priv_q <= 1'b0;
      wr_q   <= 1'b0;
      size_q <= 2'b00;
      mst_q  <= '0;
    end else if (take) begin
      pend_q <= 1'b1;
      ovr_q  <= 1'b0;
      addr_q <= err_addr;
      data_q <= err_data;
      kind_q <= err_is_data;
      priv_q <= err_priv;
      wr_q   <= err_write;
      size_q <= err_size;
      mst_q  <= err_master;
    end else if (clr) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (err_valid) begin
      ovr_q  <= 1'b1;
    end
  end

  assign mst_ext   = 4'(mst_q);
  assign attr_word = {ovr_q, 19'b0, mst_ext, wr_q, 1'b0, size_q, 2'b00, priv_q, kind_q};
  assign irq       = pend_q;

  always_comb begin
    case (rd_idx)
      2'd0:    rd_data = REG_W'(addr_q);
      2'd1:    rd_data = attr_word;
      2'd2:    rd_data = REG_W'(data_q);
      default: rd_data = '0;
    endcase
  end
endmodule

module buserr_capture_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_valid,
  input logic              clr,
  input logic              irq,
  input logic [ADDR_W-1:0] err_addr,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] data_q,
  input logic [31:0]       attr_word,
  input logic [1:0]        rd_idx,
  input logic [31:0]       rd_data
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !irq |=> irq && addr_q == $past(err_addr));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_word & 32'h7FFF_F04C) == 32'h0);

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq && err_valid && !clr |=> $stable(addr_q) && $stable(data_q) && $stable(attr_word[11:0]));

  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && err_valid && !clr |=> attr_word[31] && irq);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(err_valid));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !err_valid |=> !irq && !attr_word[31] && $stable(addr_q) && $stable(data_q));

  assert_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr && err_valid |=> irq && !attr_word[31] && addr_q == $past(err_addr));

  assert_idx3_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx == 2'd3 |-> rd_data == 32'h0);
endmodule

bind buserr_capture buserr_capture_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .clr(clr), .irq(irq),
  .err_addr(err_addr), .addr_q(addr_q), .data_q(data_q), .attr_word(attr_word),
  .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/buserr_capture_tb.sv
`timescale 1ns/1ps
module buserr_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic [31:0] err_addr = '0;
  logic [31:0] err_data = '0;
  logic        err_is_data = 1'b0;
  logic        err_priv = 1'b0;
  logic [1:0]  err_size = 2'b00;
  logic        err_write = 1'b0;
  logic [3:0]  err_master = '0;
  logic        clr = 1'b0;
  logic [1:0]  rd_idx = 2'd0;
  logic [31:0] rd_data;
  logic        irq;

  int compared = 0;
  int mismatched = 0;

  logic        m_pend = 0, m_ovr = 0;
  logic [31:0] m_addr = 0, m_data = 0;
  logic        m_kind = 0, m_priv = 0, m_wr = 0;
  logic [1:0]  m_size = 0;
  logic [3:0]  m_mst = 0;

  always #2.5 clk = ~clk;

  buserr_capture dut_i (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_addr(err_addr),
    .err_data(err_data), .err_is_data(err_is_data), .err_priv(err_priv),
    .err_size(err_size), .err_write(err_write), .err_master(err_master),
    .clr(clr), .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] exp_word(int idx);
    case (idx)
      0: return m_addr;
      1: return {m_ovr, 19'b0, m_mst, m_wr, 1'b0, m_size, 2'b00, m_priv, m_kind};
      2: return m_data;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(string scen);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #0.3;
      case (i)
        0: check({scen, " R2 R5 R8 R10 addr"}, rd_data, exp_word(i));
        1: check({scen, " R3 R4 R6 R9 attr"}, rd_data, exp_word(i));
        2: check({scen, " R2 R5 R8 data"}, rd_data, exp_word(i));
        default: check({scen, " R10 idx3"}, rd_data, exp_word(i));
      endcase
    end
    check({scen, " R7 irq"}, {31'b0, irq}, {31'b0, m_pend});
  endtask

  task automatic step(string scen, logic v, logic [31:0] a, logic [31:0] d,
                      logic k, logic p, logic [1:0] s, logic w, logic [3:0] m, logic c);
    err_valid = v; err_addr = a; err_data = d; err_is_data = k;
    err_priv = p; err_size = s; err_write = w; err_master = m; clr = c;
    @(posedge clk);
    if (v && (!m_pend || c)) begin
      m_pend = 1; m_ovr = 0; m_addr = a; m_data = d;
      m_kind = k; m_priv = p; m_size = s; m_wr = w; m_mst = m;
    end else if (c) begin
      m_pend = 0; m_ovr = 0;
    end else if (v) begin
      m_ovr = 1;
    end
    @(negedge clk);
    compare_all(scen);
  endtask

  task automatic idle(string scen);
    step(scen, 0, 32'h0, 32'h0, 0, 0, 2'b00, 0, 4'h0, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("reset R1");
    rst_n = 1'b1;
    idle("idle after reset R1");
    // R2 R3: first capture, data access, privileged, word write, master 5
    step("capture R2 R3", 1, 32'hDEAD_BEEF, 32'h1234_5678, 1, 1, 2'b10, 1, 4'h5, 0);
    idle("hold R7");
    // R5 R6: later errors only set overrun
    step("overrun R5 R6", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 2'b11, 0, 4'hF, 0);
    step("overrun2 R6", 1, 32'h0000_0001, 32'h0, 1, 0, 2'b01, 1, 4'h1, 0);
    idle("sticky R6");
    // R8: clear keeps record, drops pending and overrun
    step("clear R8", 0, 32'h0, 32'h0, 0, 0, 2'b00, 0, 4'h0, 1);
    idle("after clear R8");
    step("clear idle R8", 0, 32'h0, 32'h0, 0, 0, 2'b00, 0, 4'h0, 1);
    // R3 R4: all-ones attributes, reserved size code, master 15
    step("ones R3 R4", 1, 32'hAAAA_5555, 32'h5555_AAAA, 1, 1, 2'b11, 1, 4'hF, 0);
    step("overrun R6", 1, 32'h1, 32'h2, 0, 0, 2'b00, 0, 4'h0, 0);
    // R9: error with clear while pending gives a fresh capture
    step("fresh pending R9", 1, 32'h0BAD_F00D, 32'hCAFE_0000, 0, 0, 2'b01, 0, 4'h3, 1);
    idle("after fresh R9");
    step("clear R8", 0, 32'h0, 32'h0, 0, 0, 2'b00, 0, 4'h0, 1);
    // R9: error with clear while idle
    step("fresh idle R9", 1, 32'h8000_0000, 32'h0000_0001, 0, 1, 2'b00, 0, 4'h8, 1);
    step("overrun R6", 1, 32'h7, 32'h7, 1, 1, 2'b10, 1, 4'h7, 0);
    step("clear R8", 0, 32'h0, 32'h0, 0, 0, 2'b00, 0, 4'h0, 1);
    // R1: reset in the middle of a pending capture
    step("capture R2", 1, 32'h1357_9BDF, 32'h2468_ACE0, 1, 0, 2'b01, 1, 4'hA, 0);
    rst_n = 1'b0;
    m_pend = 0; m_ovr = 0; m_addr = 0; m_data = 0;
    m_kind = 0; m_priv = 0; m_size = 0; m_wr = 0; m_mst = 0;
    @(negedge clk);
    compare_all("mid reset R1");
    rst_n = 1'b1;
    idle("idle R1");
    finish_run();
  end
endmodule